// File: doc/BRIEF.md
# Paced Replay SPI Sample Source

This block stands in for an SPI analog-to-digital converter in front of a soft microcontroller under test. A supervisor pushes pre-recorded 16-bit samples into an on-chip FIFO through a plain valid/data write port, keeping it topped up while a long acquisition window runs. The microcontroller acts as SPI master and fetches one sample per chip-select transaction.

A divider-based pacer, clocked by the system clock, sets the replay rate. Each time it expires it marks one sample as pending and raises a one-cycle data-ready pulse, so the host can sleep until the next sample is due. A transaction only consumes a FIFO entry when a paced sample is pending. Running dry is reported through a sticky underflow flag, and pushing into a full FIFO is reported through a sticky overflow flag.

Top module: `vadc_top`

## Requirements
- R1: Samples leave the FIFO in the order they were written. `fill_level_o` equals the number of stored entries (0 to DEPTH, default 16), and `fill_full_o` is high exactly when the level equals DEPTH.
- R2: A write while the FIFO is full is dropped, leaves the stored data and level unchanged, and sets the sticky `overflow_o`. A pulse on `clr_overflow_i` clears it. A set in the same cycle wins over the clear.
- R3: While `pace_en_i` is high, `drdy_o` is a one-cycle pulse every `rate_reload_i`+1 clocks. While `pace_en_i` is low, no pulse occurs.
- R4: The SPI slave works in mode 0. It shifts 16 bits MSB first and updates `miso_o` after each falling `sclk_i` edge. `miso_o` is 0 while chip select is high.
- R5: A FIFO entry is popped on the falling edge of `cs_ni` only if a paced sample is pending, and that transaction consumes the pending mark. With nothing pending, the transaction returns 0x0000, the FIFO is unchanged and no flag is raised.
- R6: If a sample is pending but the FIFO is empty when `cs_ni` falls, the transaction returns 0x0000 and sets the sticky `underflow_o`. A pulse on `clr_underflow_i` clears it.
- R7: A fill write and a transaction pop that fall in the same cycle both take effect, so the level changes by zero.
- R8: `sclk_i` and `cs_ni` pass through two-flop synchronizers. The MSB is on `miso_o` no later than 4 clocks after `cs_ni` falls, provided each SCLK phase lasts at least 4 clocks.
- R9: After reset the FIFO is empty, both flags are low, and `drdy_o` and `miso_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Supervisor write strobe |
| fill_data_i | input | 16 | Sample to store |
| fill_full_o | output | 1 | FIFO full |
| fill_level_o | output | 5 | Stored entry count |
| rate_reload_i | input | 24 | Pacer period minus one, in clocks |
| pace_en_i | input | 1 | Pacer enable |
| clr_underflow_i | input | 1 | Write-one-to-clear for underflow |
| clr_overflow_i | input | 1 | Write-one-to-clear for overflow |
| sclk_i | input | 1 | SPI clock from master |
| cs_ni | input | 1 | SPI chip select, active low |
| miso_o | output | 1 | SPI data to master |
| drdy_o | output | 1 | One-cycle sample-ready pulse |
| underflow_o | output | 1 | Sticky underflow flag |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
A supervisor write and a transaction pop can land in the same clock. The bench starts an SPI read on a FIFO holding two samples and, at the same moment, streams eight back-to-back writes, so the synchronized chip-select edge falls inside the write burst. The outcome is judged by the level after both finish, which must match the scoreboard queue size, and by the popped value and the later drain order, which must match the queue contents with nothing lost or duplicated.

// File: rtl/vadc_pkg.sv
package vadc_pkg;
  parameter int unsigned SAMPLE_W = 16;
  typedef logic [SAMPLE_W-1:0] sample_t;
  // action taken when chip select falls
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_DATA  = 2'd1,
    LD_UNDER = 2'd2,
    LD_IDLE  = 2'd3
  } load_e;
endpackage

// File: rtl/vadc_sync.sv
module vadc_sync #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {2{RESET_VAL}};
    else         stg_q <= {stg_q[0], d_i};
  end

  assign q_o = stg_q[1];
endmodule

// File: rtl/vadc_fifo.sv
module vadc_fifo
  import vadc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  sample_t       data_i,
  input  logic          pop_i,
  output sample_t       data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o,
  output logic          drop_o
);
  sample_t       mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/vadc_pacer.sv
module vadc_pacer #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] reload_i,
  output logic             tick_o,
  output logic             drdy_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             drdy_q;

  assign tick_o = en_i & (cnt_q == '0);
  assign drdy_o = drdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      drdy_q <= 1'b0;
    end else begin
      drdy_q <= tick_o;
      if (!en_i || cnt_q == '0) cnt_q <= reload_i;
      else                      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/vadc_spi_slave.sv
module vadc_spi_slave
  import vadc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sclk_i,
  input  logic    cs_ni,
  input  logic    pending_i,
  input  logic    empty_i,
  input  sample_t data_i,
  output logic    cs_fall_o,
  output logic    pop_o,
  output logic    unf_set_o,
  output logic    miso_o
);
  logic    sclk_s, cs_s, sclk_d, cs_d;
  logic    sclk_fall;
  load_e   act;
  sample_t shreg_q;

  vadc_sync #(.RESET_VAL(1'b0)) i_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  vadc_sync #(.RESET_VAL(1'b1)) i_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign cs_fall_o = cs_d & ~cs_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  always_comb begin
    if (!cs_fall_o)     act = LD_NONE;
    else if (!pending_i) act = LD_IDLE;
    else if (empty_i)   act = LD_UNDER;
    else                act = LD_DATA;
  end

  assign pop_o     = (act == LD_DATA);
  assign unf_set_o = (act == LD_UNDER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else begin
      unique case (act)
        LD_DATA:            shreg_q <= data_i;
        LD_UNDER, LD_IDLE:  shreg_q <= '0;
        default: if (sclk_fall && !cs_s) shreg_q <= {shreg_q[SAMPLE_W-2:0], 1'b0};
      endcase
    end
  end

  assign miso_o = ~cs_s & shreg_q[SAMPLE_W-1];
endmodule

// File: rtl/vadc_top.sv
module vadc_top
  import vadc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 24,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fill_valid_i,
  input  logic [SAMPLE_W-1:0] fill_data_i,
  output logic                fill_full_o,
  output logic [LW-1:0]       fill_level_o,
  input  logic [DIV_W-1:0]    rate_reload_i,
  input  logic                pace_en_i,
  input  logic                clr_underflow_i,
  input  logic                clr_overflow_i,
  input  logic                sclk_i,
  input  logic                cs_ni,
  output logic                miso_o,
  output logic                drdy_o,
  output logic                underflow_o,
  output logic                overflow_o
);
  sample_t head;
  logic    empty, pop, drop, tick, cs_fall, unf_set;
  logic    pending_q, unf_q, ovf_q;

  vadc_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(fill_valid_i), .data_i(fill_data_i),
    .pop_i(pop), .data_o(head),
    .full_o(fill_full_o), .empty_o(empty),
    .level_o(fill_level_o), .drop_o(drop));

  vadc_pacer #(.DIV_W(DIV_W)) i_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(pace_en_i), .reload_i(rate_reload_i),
    .tick_o(tick), .drdy_o(drdy_o));

  vadc_spi_slave i_spi (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_i(sclk_i), .cs_ni(cs_ni),
    .pending_i(pending_q), .empty_i(empty), .data_i(head),
    .cs_fall_o(cs_fall), .pop_o(pop), .unf_set_o(unf_set),
    .miso_o(miso_o));

  // a tick coinciding with a transaction start arms the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      unf_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      pending_q <= tick | (pending_q & ~cs_fall);
      unf_q     <= unf_set | (unf_q & ~clr_underflow_i);
      ovf_q     <= drop | (ovf_q & ~clr_overflow_i);
    end
  end

  assign underflow_o = unf_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/vadc_chk.sv
module vadc_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 24,
  localparam int unsigned LW = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fill_valid_i,
  input logic             fill_full_o,
  input logic [LW-1:0]    fill_level_o,
  input logic [DIV_W-1:0] rate_reload_i,
  input logic             clr_underflow_i,
  input logic             clr_overflow_i,
  input logic             drdy_o,
  input logic             underflow_o,
  input logic             overflow_o
);
  assert_drdy_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_o && rate_reload_i != '0) |=> !drdy_o);

  assert_ovf_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_full_o) |=> overflow_o);

  assert_ovf_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr_overflow_i) |=> overflow_o);

  assert_unf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !clr_underflow_i) |=> underflow_o);

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_level_o <= LW'(DEPTH));

  assert_level_noinc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i |=> fill_level_o <= $past(fill_level_o));

  assert_full_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_full_o && fill_valid_i) |=> fill_level_o >= $past(fill_level_o) - 1'b1);
endmodule

bind vadc_top vadc_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) i_vadc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fill_valid_i(fill_valid_i),
  .fill_full_o(fill_full_o), .fill_level_o(fill_level_o),
  .rate_reload_i(rate_reload_i), .clr_underflow_i(clr_underflow_i),
  .clr_overflow_i(clr_overflow_i), .drdy_o(drdy_o),
  .underflow_o(underflow_o), .overflow_o(overflow_o));

// File: tb/test_vadc_top.sv
module test_vadc_top;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_valid = 1'b0;
  logic [15:0] fill_data = '0;
  logic fill_full;
  logic [LW-1:0] fill_level;
  logic [23:0] reload = 24'd49;
  logic pace_en = 1'b0, clr_unf = 1'b0, clr_ovf = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1;
  logic miso, drdy, unf, ovf;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  vadc_top i_vadc_top (
    .clk_i(clk), .rst_ni(rst_n), .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .fill_full_o(fill_full), .fill_level_o(fill_level), .rate_reload_i(reload),
    .pace_en_i(pace_en), .clr_underflow_i(clr_unf), .clr_overflow_i(clr_ovf),
    .sclk_i(sclk), .cs_ni(cs_n), .miso_o(miso), .drdy_o(drdy),
    .underflow_o(unf), .overflow_o(ovf));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    fill_valid = 1'b1; fill_data = v;
    if (exp_q.size() < DEPTH) exp_q.push_back(v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic burst(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fill_valid = 1'b1; fill_data = base + 16'(i);
      if (exp_q.size() < DEPTH) exp_q.push_back(base + 16'(i));
    end
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // read one word; popped: a paced sample is known to be pending
  task automatic spi_read(input bit popped, input string req);
    logic [15:0] got, want;
    bit want_unf;
    want = 16'h0; want_unf = 1'b0;
    if (popped) begin
      if (exp_q.size() > 0) want = exp_q.pop_front();
      else want_unf = 1'b1;
    end
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 15; b >= 0; b--) begin
      got[b] = miso;
      sclk = 1'b1; repeat (6) @(negedge clk);
      sclk = 1'b0; repeat (6) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(req, 32'(got), 32'(want));
    if (want_unf) check("R6 underflow flag", 32'(unf), 32'd1);
  endtask

  task automatic wait_drdy();
    do @(negedge clk); while (!drdy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 level", 32'(fill_level), 0);
    check("R9 full", 32'(fill_full), 0);
    check("R9 flags", {30'd0, unf, ovf}, 0);
    check("R9 drdy/miso", {30'd0, drdy, miso}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 fill
    push(16'hA5C3); push(16'h1234); push(16'h8001);
    @(negedge clk);
    check("R1 level after 3", 32'(fill_level), 3);

    // R5 no pending sample: zero, FIFO untouched
    spi_read(1'b0, "R5 no-pending read");
    check("R5 level unchanged", 32'(fill_level), 3);
    check("R5 no underflow", 32'(unf), 0);

    // R3 pacer period and pulse width
    pace_en = 1'b1;
    wait_drdy();
    @(negedge clk);
    check("R3 pulse width", 32'(drdy), 0);
    t = 1;
    while (!drdy) begin @(negedge clk); t++; end
    check("R3 period", t, 50);

    // R4/R8 paced reads, MSB first, first bit 4 clocks after cs falls
    spi_read(1'b1, "R4 read A5C3");
    spi_read(1'b1, "R8 read 1234");
    check("R1 level after 2 pops", 32'(fill_level), 1);
    spi_read(1'b1, "R4 read 8001");
    check("R4 miso low with cs high", 32'(miso), 0);

    // R6 underflow
    spi_read(1'b1, "R6 empty read");
    @(negedge clk); clr_unf = 1'b1;
    @(negedge clk); clr_unf = 1'b0;
    @(negedge clk);
    check("R6 cleared", 32'(unf), 0);

    // R3 no pulses while disabled
    pace_en = 1'b0;
    t = 0;
    repeat (200) begin @(negedge clk); if (drdy) t++; end
    check("R3 quiet when disabled", t, 0);

    // R2 overflow: fill DEPTH+1
    burst(DEPTH + 1, 16'h4000);
    @(negedge clk);
    check("R2 level at full", 32'(fill_level), DEPTH);
    check("R1 full flag", 32'(fill_full), 1);
    check("R2 overflow set", 32'(ovf), 1);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    @(negedge clk);
    check("R2 overflow cleared", 32'(ovf), 0);

    // drain: dropped word must never appear
    pace_en = 1'b1;
    wait_drdy();
    while (exp_q.size() > 2) spi_read(1'b1, "R2 drain order");

    // R7 write burst overlapping a pop
    fork
      spi_read(1'b1, "R7 concurrent pop");
      burst(8, 16'h7700);
    join
    check("R7 level", 32'(fill_level), exp_q.size());

    // streaming refill while replaying
    for (int i = 0; i < 12; i++) begin
      push(16'hC000 ^ 16'(i * 37));
      spi_read(1'b1, "R1 stream order");
      check("R1 stream level", 32'(fill_level), exp_q.size());
    end
    while (exp_q.size() > 0) spi_read(1'b1, "R1 final drain");
    check("R6 no underflow on drain", 32'(unf), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule